// File: doc/BRIEF.md
# SPI Frame Master with Select and Gap Delays

This block is the master side of a four-wire serial link. Words written into a transmit queue are shifted out on MOSI one fixed-width frame at a time, most significant bit first. The word captured on MISO during the same frame lands in a receive queue. Clock polarity, clock phase and the SCK half-period are set through a small write-only configuration port.

The block drives no clock until the transmitter is enabled and the transmit queue holds at least one word. Once a frame starts, two programmable waits shape the select line. The first sits between the fall of SS and the first SCK transition. The second follows the last transition of every frame. After that second wait, SS stays low and the next frame begins if more data is queued. Otherwise SS is released.

Two threshold flags report queue fill in bytes, and a maskable interrupt reports that the transmit queue can take another word. Timing fields are frozen while the transmitter is enabled or a frame is running, so software must disable the transmitter before it reconfigures the link.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, SS is high, SCK is low, the transmit queue is not full, the receive queue is empty, the interrupt is low, and both alarm flags are high, because both thresholds reset to zero.
- R2: SS stays high and SCK stays at its idle level while the transmitter is disabled, even with words queued. The same holds while the transmitter is enabled and the transmit queue is empty.
- R3: A frame is W bits on MOSI, most significant bit first, carried by 2·W SCK transitions spaced H clock cycles apart. H is the divider value, and a divider of 0 acts as 1. SCK rests at the polarity bit (ctrl bit 2) whenever SS is high.
- R4: With the phase bit (ctrl bit 3) clear, MISO is captured on the first transition of each bit period and MOSI changes on the second. With it set, MOSI changes on the first transition and MISO is captured on the second. The captured word is stored in the receive queue most significant bit first.
- R5: The first SCK transition after SS falls comes L + H + 1 cycles later, where L is the lead delay register.
- R6: After the last transition of a frame, the block counts T + 1 cycles, where T is the gap delay register. If the transmit queue is then empty, SS rises at that point. Otherwise SS stays low and the next frame's first transition follows H cycles later.
- R7: While the transmitter is enabled or a frame is in progress, writes to the divider, the lead delay, the gap delay, the polarity bit and the phase bit have no effect.
- R8: The transmit alarm is high when (queued words × W/8) is at least the transmit threshold. The full flag is high at DEPTH words, and a push while full is discarded.
- R9: The receive alarm is high when (free entries × W/8) is at least the receive threshold.
- R10: The interrupt equals the interrupt-enable bit (ctrl bit 4) ANDed with "transmit queue not full".
- R11: While the receive enable (ctrl bit 1) is clear, completed frames are not stored. The transmit enable is ctrl bit 0.

Configuration addresses: 0 control, 1 divider, 2 lead delay, 3 gap delay, 4 transmit threshold (bytes, 8 bits), 5 receive threshold (bytes, 8 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | DIV_W | Configuration write data |
| tx_push | input | 1 | Push tx_data into the transmit queue |
| tx_data | input | W | Word to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | W | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| tx_alarm | output | 1 | Transmit fill threshold reached |
| rx_alarm | output | 1 | Receive free-space threshold reached |
| irq | output | 1 | Transmit-ready interrupt |
| sck | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with W = 16 and DEPTH = 4, so every frame is short and the queues fill in four pushes. Each frame and its timing are checked edge by edge across all four polarity/phase modes, divider values 0, 2 and 3, and two lead and two gap settings. The four-entry queues let the bench walk every fill level against every byte threshold from 0 to one past capacity. They also make the full-queue push and a run of back-to-back frames cheap to reach.

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [DIV_W-1:0] cfg_wdata,
  input  logic             tx_push,
  input  logic [W-1:0]     tx_data,
  output logic             tx_full,
  input  logic             rx_pop,
  output logic [W-1:0]     rx_data,
  output logic             rx_empty,
  output logic             tx_alarm,
  output logic             rx_alarm,
  output logic             irq,
  output logic             sck,
  output logic             ss_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int AW  = $clog2(DEPTH);
  localparam int BPW = W / 8;
  localparam int EW  = $clog2(2 * W);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * W - 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_XFER, S_GAP} st_t;

  logic             tx_en, rx_en, cpol, cpha, ie;
  logic [DIV_W-1:0] div_q;
  logic [DLY_W-1:0] lead_q, gap_q;
  logic [7:0]       tx_thr, rx_thr;

  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic [EW-1:0]    edg;
  logic             ph, ss_q;
  logic [W-1:0]     txsh, rxsh;

  logic busy, lock;
  assign busy = (st != S_IDLE);
  assign lock = tx_en | busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0; rx_en <= 1'b0; cpol <= 1'b0; cpha <= 1'b0; ie <= 1'b0;
      div_q <= DIV_W'(1); lead_q <= '0; gap_q <= '0;
      tx_thr <= '0; rx_thr <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: begin
          tx_en <= cfg_wdata[0];
          rx_en <= cfg_wdata[1];
          ie    <= cfg_wdata[4];
          if (!lock) begin
            cpol <= cfg_wdata[2];
            cpha <= cfg_wdata[3];
          end
        end
        3'd1: if (!lock) div_q  <= cfg_wdata;
        3'd2: if (!lock) lead_q <= cfg_wdata[DLY_W-1:0];
        3'd3: if (!lock) gap_q  <= cfg_wdata[DLY_W-1:0];
        3'd4: tx_thr <= cfg_wdata[7:0];
        3'd5: rx_thr <= cfg_wdata[7:0];
        default: ;
      endcase
    end
  end

  // transmit queue
  logic [W-1:0] tmem [DEPTH];
  logic [AW:0]  twp, trp, tcnt;
  logic         tx_empty, tx_pop;
  logic [W-1:0] tx_head;

  assign tcnt     = twp - trp;
  assign tx_full  = (tcnt == (AW+1)'(DEPTH));
  assign tx_empty = (tcnt == '0);
  assign tx_head  = tmem[trp[AW-1:0]];

  always_ff @(posedge clk)
    if (tx_push && !tx_full) tmem[twp[AW-1:0]] <= tx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0;
    end else begin
      if (tx_push && !tx_full) twp <= twp + 1'b1;
      if (tx_pop) trp <= trp + 1'b1;
    end
  end

  // receive queue
  logic [W-1:0] rmem [DEPTH];
  logic [AW:0]  rwp, rrp, rcnt;
  logic         rx_full, rx_push;
  logic [W-1:0] rx_word;

  assign rcnt     = rwp - rrp;
  assign rx_full  = (rcnt == (AW+1)'(DEPTH));
  assign rx_empty = (rcnt == '0);
  assign rx_data  = rmem[rrp[AW-1:0]];

  always_ff @(posedge clk)
    if (rx_push) rmem[rwp[AW-1:0]] <= rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rwp <= '0; rrp <= '0;
    end else begin
      if (rx_push) rwp <= rwp + 1'b1;
      if (rx_pop && !rx_empty) rrp <= rrp + 1'b1;
    end
  end

  // frame engine
  logic [DIV_W-1:0] hp_m1;
  logic start_ok, tick, samp, shft, last;

  assign hp_m1    = (div_q == '0) ? '0 : div_q - 1'b1;
  assign start_ok = tx_en & ~tx_empty;
  assign tick     = (st == S_XFER) && (cnt == '0);
  assign samp     = tick && (edg[0] == cpha);
  assign shft     = tick && (edg[0] != cpha) && (edg != '0);
  assign last     = tick && (edg == LAST_EDGE);
  assign rx_word  = samp ? {rxsh[W-2:0], miso} : rxsh;
  assign rx_push  = last && rx_en && !rx_full;
  assign tx_pop   = start_ok && ((st == S_IDLE) || (st == S_GAP && cnt == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; edg <= '0; ph <= 1'b0; ss_q <= 1'b1;
      txsh <= '0; rxsh <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_ok) begin
          txsh <= tx_head;
          ss_q <= 1'b0;
          cnt  <= DIV_W'(lead_q);
          st   <= S_LEAD;
        end
        S_LEAD: if (cnt == '0) begin
          st  <= S_XFER;
          cnt <= hp_m1;
          edg <= '0;
        end else cnt <= cnt - 1'b1;
        S_XFER: if (cnt != '0) cnt <= cnt - 1'b1;
        else begin
          ph  <= ~ph;
          edg <= edg + 1'b1;
          cnt <= hp_m1;
          if (samp) rxsh <= {rxsh[W-2:0], miso};
          if (shft) txsh <= {txsh[W-2:0], 1'b0};
          if (last) begin
            st  <= S_GAP;
            cnt <= DIV_W'(gap_q);
          end
        end
        S_GAP: if (cnt == '0) begin
          if (start_ok) begin
            txsh <= tx_head;
            st   <= S_XFER;
            cnt  <= hp_m1;
            edg  <= '0;
          end else begin
            ss_q <= 1'b1;
            st   <= S_IDLE;
          end
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sck  = cpol ^ ph;
  assign ss_n = ss_q;
  assign mosi = txsh[W-1];

  logic [15:0] tx_bytes, rx_free_bytes;
  assign tx_bytes      = 16'(tcnt) * 16'(BPW);
  assign rx_free_bytes = 16'((AW+1)'(DEPTH) - rcnt) * 16'(BPW);
  assign tx_alarm      = (tx_bytes >= {8'd0, tx_thr});
  assign rx_alarm      = (rx_free_bytes >= {8'd0, rx_thr});
  assign irq           = ie & ~tx_full;
endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk #(
  parameter int CW = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ss_n,
  input logic          sck,
  input logic          cpol,
  input logic          tx_en,
  input logic          tx_full,
  input logic          tx_push,
  input logic [CW-1:0] tcnt,
  input logic          rx_en,
  input logic [CW-1:0] rcnt,
  input logic [DW-1:0] div_q
);
  logic tx_empty;
  assign tx_empty = (tcnt == '0);

  AST_IDLE_SCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> (sck == cpol)); // R3
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $past(tx_en && !tx_empty)); // R2
  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_push) |=> (tcnt <= $past(tcnt))); // R8
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en || !ss_n) |=> $stable(div_q)); // R7
  AST_RX_OFF_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (rcnt <= $past(rcnt))); // R11
endmodule

bind spi_frame_master spi_frame_master_chk #(.CW(AW + 1), .DW(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .cpol(cpol),
  .tx_en(tx_en), .tx_full(tx_full), .tx_push(tx_push), .tcnt(tcnt),
  .rx_en(rx_en), .rcnt(rcnt), .div_q(div_q)
);

// File: tb/tb_spi_frame_master.sv
`timescale 1ns/1ps
module tb_spi_frame_master;
  localparam int TW = 16, TD = 4, BPW = TW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [2:0] cfg_addr = '0; logic [15:0] cfg_wdata = '0;
  logic tx_push = 1'b0; logic [TW-1:0] tx_data = '0; logic tx_full;
  logic rx_pop = 1'b0; logic [TW-1:0] rx_data; logic rx_empty;
  logic tx_alarm, rx_alarm, irq, sck, ss_n, mosi, miso;

  always #2 clk = ~clk;

  spi_frame_master #(.W(TW), .DEPTH(TD)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
    .tx_alarm(tx_alarm), .rx_alarm(rx_alarm), .irq(irq),
    .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso));

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] txw(input int ci, input int f);
    return TW'(32'h9A3C ^ (ci * 32'h1F1 + f * 32'h5A5));
  endfunction
  function automatic logic [TW-1:0] slv(input int f);
    return TW'(32'hC35A ^ (f * 32'h2E3));
  endfunction
  function automatic logic [15:0] ctrl(input bit txe, input bit rxe, input bit cp, input bit ph, input bit ie);
    return {11'd0, ie, ph, cp, rxe, txe};
  endfunction

  // slave model and edge monitor
  int eL, eH, eT; logic ecpol, ecpha;
  int cyc = 0, t_ss = 0, t_prev = 0, t_last = 0, ntog = 0, fr = 0, bidx = 0;
  logic pss = 1'b1, psck = 1'b0, lead_e, samp_e;
  logic [TW-1:0] capw = '0, sword = '0;
  logic [TW-1:0] exp_tx [TD+1];

  assign miso = (bidx < TW) ? sword[TW-1-bidx] : 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (pss && !ss_n) t_ss = cyc;
    if (!pss && ss_n) chk(cyc - t_last == eT + 1, "R6 gap before SS release", 32'(cyc - t_last), 32'(eT + 1));
    if (sck !== psck && !ss_n) begin
      if (ntog == 0) begin
        if (fr == 0) chk(cyc - t_ss == eL + eH + 1, "R5 SS to first SCK", 32'(cyc - t_ss), 32'(eL + eH + 1));
        else chk(cyc - t_last == eT + 1 + eH, "R6 back-to-back gap", 32'(cyc - t_last), 32'(eT + 1 + eH));
      end else chk(cyc - t_prev == eH, "R3 half period", 32'(cyc - t_prev), 32'(eH));
      lead_e = (sck != ecpol);
      samp_e = ecpha ? !lead_e : lead_e;
      if (samp_e) begin
        capw = {capw[TW-2:0], mosi};
        bidx++;
      end
      ntog++;
      t_prev = cyc;
      if (ntog == 2 * TW) begin
        chk(capw == exp_tx[fr], "R3 R4 MOSI word msb first", 32'(capw), 32'(exp_tx[fr]));
        t_last = cyc; ntog = 0; bidx = 0; fr++; sword = slv(fr);
      end
    end
    pss = ss_n; psck = sck;
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic push(input logic [TW-1:0] d);
    @(negedge clk); tx_push = 1'b1; tx_data = d;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic tx_sweep(input int k, input bit rxe, input bit cp, input bit ph);
    for (int thr = 0; thr <= TD * BPW + 1; thr++) begin
      wr(3'd4, 16'(thr));
      chk(tx_alarm == (k * BPW >= thr), "R8 tx alarm", 32'(tx_alarm), 32'(k * BPW >= thr));
    end
    chk(tx_full == (k >= TD), "R8 full flag", 32'(tx_full), 32'(k >= TD));
    wr(3'd0, ctrl(0, rxe, cp, ph, 1));
    chk(irq == (k < TD), "R10 irq enabled", 32'(irq), 32'(k < TD));
    wr(3'd0, ctrl(0, rxe, cp, ph, 0));
    chk(irq == 1'b0, "R10 irq masked", 32'(irq), 0);
  endtask

  task automatic run_cfg(input int ci, input bit cp, input bit ph, input int dv, input int ld,
                         input int tr, input int nfr, input bit rxe, input bit sw);
    bit bad;
    wr(3'd1, 16'(dv)); wr(3'd2, 16'(ld)); wr(3'd3, 16'(tr));
    wr(3'd0, ctrl(0, rxe, cp, ph, 0));
    eL = ld; eH = (dv == 0) ? 1 : dv; eT = tr; ecpol = cp; ecpha = ph;
    fr = 0; ntog = 0; bidx = 0; capw = '0; sword = slv(0);
    if (sw) tx_sweep(0, rxe, cp, ph);
    for (int f = 0; f < nfr; f++) begin
      exp_tx[f] = txw(ci, f);
      push(exp_tx[f]);
      if (sw) tx_sweep(f + 1, rxe, cp, ph);
    end
    if (nfr == TD) begin
      push(~txw(ci, 9));
      if (sw) tx_sweep(TD, rxe, cp, ph);
    end
    bad = 0;
    repeat (30) begin @(negedge clk); if (ss_n !== 1'b1 || sck !== cp) bad = 1; end
    chk(!bad, "R2 disabled transmitter stays quiet", 32'(bad), 0);
    wr(3'd0, ctrl(1, rxe, cp, ph, 0));
    wr(3'd1, 16'(dv + 5)); wr(3'd2, 16'(ld + 3)); wr(3'd3, 16'(tr + 2));
    wr(3'd0, ctrl(1, rxe, !cp, !ph, 0)); // R7 locked writes
    wait (fr == nfr && ss_n);
    bad = 0;
    repeat (20) begin @(negedge clk); if (ss_n !== 1'b1 || sck !== cp) bad = 1; end
    chk(!bad, "R2 R7 empty queue stays quiet at old polarity", 32'(bad), 0);
    chk(fr == nfr, "R8 push while full discarded", 32'(fr), 32'(nfr));
    wr(3'd0, ctrl(0, rxe, cp, ph, 0));
    if (rxe) begin
      for (int j = 0; j < nfr; j++) begin
        if (sw) for (int thr = 0; thr <= TD * BPW + 1; thr++) begin
          wr(3'd5, 16'(thr));
          chk(rx_alarm == (j * BPW >= thr), "R9 rx alarm", 32'(rx_alarm), 32'(j * BPW >= thr));
        end
        @(negedge clk);
        chk(rx_data == slv(j), "R4 received word", 32'(rx_data), 32'(slv(j)));
        rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
      end
    end
    chk(rx_empty == 1'b1, "R11 R4 receive queue drained or unused", 32'(rx_empty), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ss_n == 1'b1, "R1 ss_n", 32'(ss_n), 1);
    chk(sck == 1'b0, "R1 sck", 32'(sck), 0);
    chk(tx_full == 1'b0 && rx_empty == 1'b1, "R1 queue flags", {30'd0, tx_full, rx_empty}, 1);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    chk(tx_alarm && rx_alarm, "R1 alarms", {30'd0, tx_alarm, rx_alarm}, 3);
    begin
      int ci = 0;
      for (int m = 0; m < 4; m++)
        for (int d = 0; d < 3; d++)
          for (int l = 0; l < 2; l++)
            for (int t = 0; t < 2; t++) begin
              run_cfg(ci, m[1], m[0], (d == 0) ? 0 : d + 1, l * 2, t * 3, 2, 1, 0);
              ci++;
            end
      run_cfg(ci, 1, 0, 2, 4, 1, TD, 1, 1);
      run_cfg(ci + 1, 0, 1, 1, 1, 2, 1, 0, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog (all requirements) act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule